// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Vectoring

This block keeps the return addresses of a small processor core. It has a three-deep stack of 11-bit program-counter values, and it holds the logic that decides when an external interrupt is taken. Every action happens on a one-clock instruction-cycle strobe. On that strobe the core may ask for a push of the next sequential address, or for a pop. When a pop is done, the block returns the address on top of the stack as the program-counter load value, with a one-cycle load strobe.

The interrupt pin is synchronised and then sampled once per instruction cycle. A request becomes pending only when all of the following hold:
- the enable bit is set;
- the pin has been seen going from high to low;
- the pin then stays low for two consecutive samples.

The request is acknowledged on the first strobe where three conditions hold: no chain of back-to-back control transfers is in progress, no push is requested and no pop is requested. On acknowledge the block does three things:
- it pushes the next sequential address together with the core's skip-pending flag;
- it loads the program counter with the fixed vector;
- it pulses an enable-clear output.

When that entry is popped later, the saved skip flag is handed back so that the core skips the instruction after the return. The core's decoder drives the request and status inputs. Decode, arithmetic and memory are outside this block.

Top module: `retstk_irq`

## Requirements
- R1: After reset, `pc_load` is 0, and `pc_load_vld`, `en_clr` and `skip_restore` are 0. All stack entries and their saved skip bits are 0, so pops straight after reset return address 0 with `skip_restore` 0.
- R2: A push on a strobe shifts the stack down. The pushed address becomes the top, the top moves to the middle, the middle moves to the bottom, and the old bottom is lost. An ordinary push saves a skip bit of 0.
- R3: A pop on a strobe drives `pc_load` with the top address and pulses `pc_load_vld`. The middle entry moves to the top and the bottom moves to the middle. The bottom entry stays as it was, so it ends up duplicated. A push and a pop on the same strobe is a protocol error; in that case only the pop is done.
- R4: A push followed by a pop (a table lookup) returns the pushed address. Its net effect on the stack is that the middle entry is copied into the bottom entry.
- R5: A request becomes pending only under these conditions:
  - `int_en` is 1 at the qualifying sample;
  - the synchronised pin was sampled high;
  - the pin was then sampled low on two consecutive strobes.

  A low that lasts only one strobe sample is ignored. A pulse that qualifies while `int_en` is 0 is also ignored.
- R6: On acknowledge, `push_addr` is pushed, `pc_load` becomes the vector (default 0x0FF), and `pc_load_vld` and `en_clr` pulse together for one clock.
- R7: A pending request is not acknowledged on a strobe where `xfer_chain`, `push_req` or `pop_req` is high, or where `int_en` is 0. It is acknowledged on the first strobe that is clear of all of these.
- R8: On acknowledge, `skip_pend` is saved with the pushed entry. The pop of that entry raises `skip_restore` together with `pc_load_vld`.
- R9: Outputs change only on clock edges where `cyc_stb` is high. `pc_load_vld`, `en_clr` and `skip_restore` are single-clock pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cyc_stb | input | 1 | Instruction-cycle strobe, one clock wide |
| push_req | input | 1 | Push `push_addr` on this strobe |
| pop_req | input | 1 | Pop the top entry to the program counter |
| push_addr | input | 11 | Next sequential address |
| int_pin | input | 1 | Asynchronous interrupt pin, active low-going |
| int_en | input | 1 | Interrupt enable bit |
| skip_pend | input | 1 | Core has a skip pending |
| xfer_chain | input | 1 | Core is within a run of consecutive control transfers |
| pc_load | output | 11 | Program-counter load value |
| pc_load_vld | output | 1 | Load strobe for `pc_load` |
| en_clr | output | 1 | Pulse that clears the interrupt enable bit |
| skip_restore | output | 1 | Skip flag handed back with a pop |

## Verification
A wrong stack entry stays hidden until it is popped. The bench therefore follows every push pattern with pops, including pops past the depth, so that a corrupted entry, a lost bottom duplicate or a missing skip bit shows up on `pc_load` or `skip_restore` within three strobes. Faults in the qualifier or the deferral logic show up as an `en_clr` pulse that comes one strobe early, one strobe late, or not at all. For this reason the bench checks `en_clr` on every strobe against its own model of the pin samples.

// File: rtl/retstk_pkg.sv
package retstk_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // operation applied to the stack on a strobe
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_PUSH = 2'd1,
      OP_POP  = 2'd2,
      OP_ACK  = 2'd3
   } stk_op_e;
endpackage

// File: rtl/retstk_sync.sv
module retstk_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   timeunit 1ns;
   timeprecision 1ps;

   if (STAGES < 2) begin : g_bad_stages
      $error("retstk_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
      else        sh_q <= {sh_q[STAGES-2:0], din};
   end

   assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/retstk_irq_qual.sv
module retstk_irq_qual #(
   parameter int QUAL = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic pin_s,
   input  logic int_en,
   input  logic ack,
   output logic pend
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int CW = $clog2(QUAL + 1);

   if (QUAL < 1) begin : g_bad_qual
      $error("retstk_irq_qual: QUAL must be at least 1");
   end

   logic          armed_q;
   logic [CW-1:0] low_cnt_q;
   logic          last_low;
   logic          qualify;

   assign last_low = (low_cnt_q == CW'(QUAL - 1));
   assign qualify  = stb && !pin_s && armed_q && last_low && int_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q   <= 1'b0;
         low_cnt_q <= '0;
      end else if (stb) begin
         if (pin_s) begin
            armed_q   <= 1'b1;
            low_cnt_q <= '0;
         end else if (armed_q) begin
            if (last_low) begin
               armed_q   <= 1'b0;
               low_cnt_q <= '0;
            end else begin
               low_cnt_q <= low_cnt_q + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend <= 1'b0;
      else if (ack)     pend <= 1'b0;
      else if (qualify) pend <= 1'b1;
   end
endmodule

// File: rtl/retstk_store.sv
module retstk_store
   import retstk_pkg::*;
#(
   parameter int AW    = 11,
   parameter int DEPTH = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  stk_op_e       op,
   input  logic [AW-1:0] push_addr,
   input  logic          push_skip,
   output logic [AW-1:0] top_addr,
   output logic          top_skip
);
   timeunit 1ns;
   timeprecision 1ps;

   if (DEPTH < 2) begin : g_bad_depth
      $error("retstk_store: DEPTH must be at least 2");
   end

   logic [DEPTH-1:0][AW-1:0] addr_q, addr_d;
   logic [DEPTH-1:0]         skip_q, skip_d;

   always_comb begin
      addr_d = addr_q;
      skip_d = skip_q;
      unique case (op)
         OP_PUSH, OP_ACK: begin
            addr_d = {addr_q[DEPTH-2:0], push_addr};
            skip_d = {skip_q[DEPTH-2:0], push_skip};
         end
         OP_POP: begin
            addr_d = {addr_q[DEPTH-1], addr_q[DEPTH-1:1]};
            skip_d = {skip_q[DEPTH-1], skip_q[DEPTH-1:1]};
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         skip_q <= '0;
      end else begin
         addr_q <= addr_d;
         skip_q <= skip_d;
      end
   end

   assign top_addr = addr_q[0];
   assign top_skip = skip_q[0];
endmodule

// File: rtl/retstk_irq.sv
module retstk_irq
   import retstk_pkg::*;
#(
   parameter int          AW        = 11,
   parameter int          DEPTH     = 3,
   parameter int          QUAL      = 2,
   parameter int          SYNC      = 2,
   parameter logic [31:0] VECTOR    = 32'h0FF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cyc_stb,
   input  logic          push_req,
   input  logic          pop_req,
   input  logic [AW-1:0] push_addr,
   input  logic          int_pin,
   input  logic          int_en,
   input  logic          skip_pend,
   input  logic          xfer_chain,
   output logic [AW-1:0] pc_load,
   output logic          pc_load_vld,
   output logic          en_clr,
   output logic          skip_restore
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [AW-1:0] VEC = VECTOR[AW-1:0];

   if ((VECTOR >> AW) != 0) begin : g_bad_vector
      $error("retstk_irq: VECTOR does not fit in AW bits");
   end

   logic          pin_s;
   logic          pend;
   logic          ack;
   stk_op_e       op;
   logic [AW-1:0] top_addr;
   logic          top_skip;

   retstk_sync #(.STAGES(SYNC), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (int_pin),
      .dout  (pin_s)
   );

   assign ack = cyc_stb && pend && int_en && !xfer_chain && !push_req && !pop_req;

   retstk_irq_qual #(.QUAL(QUAL)) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (cyc_stb),
      .pin_s  (pin_s),
      .int_en (int_en),
      .ack    (ack),
      .pend   (pend)
   );

   always_comb begin
      if (!cyc_stb)     op = OP_NONE;
      else if (pop_req) op = OP_POP;
      else if (ack)     op = OP_ACK;
      else if (push_req) op = OP_PUSH;
      else              op = OP_NONE;
   end

   retstk_store #(.AW(AW), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .push_addr (push_addr),
      .push_skip (op == OP_ACK ? skip_pend : 1'b0),
      .top_addr  (top_addr),
      .top_skip  (top_skip)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_load      <= '0;
         pc_load_vld  <= 1'b0;
         en_clr       <= 1'b0;
         skip_restore <= 1'b0;
      end else begin
         pc_load_vld  <= 1'b0;
         en_clr       <= 1'b0;
         skip_restore <= 1'b0;
         unique case (op)
            OP_POP: begin
               pc_load      <= top_addr;
               pc_load_vld  <= 1'b1;
               skip_restore <= top_skip;
            end
            OP_ACK: begin
               pc_load     <= VEC;
               pc_load_vld <= 1'b1;
               en_clr      <= 1'b1;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/retstk_irq_chk.sv
module retstk_irq_chk #(
   parameter int          AW     = 11,
   parameter logic [31:0] VECTOR = 32'h0FF
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cyc_stb,
   input logic          push_req,
   input logic          pop_req,
   input logic          int_en,
   input logic          xfer_chain,
   input logic [AW-1:0] pc_load,
   input logic          pc_load_vld,
   input logic          en_clr,
   input logic          skip_restore
);
   timeunit 1ns;
   timeprecision 1ps;

   a_r3_no_push_with_pop: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_stb |-> !(push_req && pop_req));

   a_r6_clr_loads_vector: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr |-> (pc_load_vld && pc_load == VECTOR[AW-1:0]));

   a_r5_clr_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_clr) |-> $past(int_en));

   a_r7_no_ack_in_chain: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_clr) |-> !$past(xfer_chain));

   a_r8_restore_with_pop: assert property (@(posedge clk) disable iff (!rst_n)
      skip_restore |-> (pc_load_vld && !en_clr));

   a_r9_pc_held_off_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_stb |=> $stable(pc_load));

   a_r9_vld_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_stb |=> !pc_load_vld);
endmodule

bind retstk_irq retstk_irq_chk #(.AW(AW), .VECTOR(VECTOR)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cyc_stb      (cyc_stb),
   .push_req     (push_req),
   .pop_req      (pop_req),
   .int_en       (int_en),
   .xfer_chain   (xfer_chain),
   .pc_load      (pc_load),
   .pc_load_vld  (pc_load_vld),
   .en_clr       (en_clr),
   .skip_restore (skip_restore)
);

// File: tb/sim_retstk_irq.sv
module sim_retstk_irq;
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [10:0] VEC = 11'h0FF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_stb = 1'b0, push_req = 1'b0, pop_req = 1'b0;
   logic [10:0] push_addr = '0;
   logic        int_pin = 1'b1, int_en = 1'b0, skip_pend = 1'b0, xfer_chain = 1'b0;
   logic [10:0] pc_load;
   logic        pc_load_vld, en_clr, skip_restore;

   int n_cmp = 0;
   int n_bad = 0;

   // bench model state
   logic [10:0] ma [3];
   logic        ms [3];
   logic        m_pin = 1'b1, m_armed = 1'b0, m_pend = 1'b0;
   int          m_cnt = 0;
   logic [10:0] m_pc = '0;

   always #2.5 clk = ~clk;

   retstk_irq u0 (
      .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .push_req(push_req),
      .pop_req(pop_req), .push_addr(push_addr), .int_pin(int_pin),
      .int_en(int_en), .skip_pend(skip_pend), .xfer_chain(xfer_chain),
      .pc_load(pc_load), .pc_load_vld(pc_load_vld), .en_clr(en_clr),
      .skip_restore(skip_restore)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic void m_push(input logic [10:0] a, input logic s);
      ma[2] = ma[1]; ms[2] = ms[1];
      ma[1] = ma[0]; ms[1] = ms[0];
      ma[0] = a;     ms[0] = s;
   endfunction

   task automatic set_pin(input logic v);
      m_pin   = v;
      int_pin = v;
   endtask

   // one instruction cycle: three idle clocks, then a strobe
   task automatic step(input logic ps, input logic po, input logic [10:0] ad,
                       input logic sk, input logic ch, input logic en,
                       input string tag);
      logic ack, qual, e_vld, e_clr, e_sr;
      repeat (3) @(negedge clk);
      chk("R9", "vld idle", 32'(pc_load_vld), 0);
      chk("R9", "clr idle", 32'(en_clr), 0);
      push_req = ps; pop_req = po; push_addr = ad; skip_pend = sk;
      xfer_chain = ch; int_en = en; cyc_stb = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cyc_stb = 1'b0; push_req = 1'b0; pop_req = 1'b0;
      // model
      ack  = m_pend && en && !ch && !ps && !po;
      qual = 1'b0;
      if (m_pin) begin
         m_armed = 1'b1; m_cnt = 0;
      end else if (m_armed) begin
         m_cnt++;
         if (m_cnt == 2) begin m_armed = 1'b0; m_cnt = 0; qual = en; end
      end
      if (ack) m_pend = 1'b0;
      else if (qual) m_pend = 1'b1;
      e_vld = 1'b0; e_clr = 1'b0; e_sr = 1'b0;
      if (po) begin
         m_pc = ma[0]; e_vld = 1'b1; e_sr = ms[0];
         ma[0] = ma[1]; ms[0] = ms[1];
         ma[1] = ma[2]; ms[1] = ms[2];
      end else if (ack) begin
         m_push(ad, sk);
         m_pc = VEC; e_vld = 1'b1; e_clr = 1'b1;
      end else if (ps) begin
         m_push(ad, 1'b0);
      end
      chk(tag, "pc_load", 32'(pc_load), 32'(m_pc));
      chk(tag, "pc_load_vld", 32'(pc_load_vld), 32'(e_vld));
      chk(tag, "en_clr", 32'(en_clr), 32'(e_clr));
      chk(tag, "skip_restore", 32'(skip_restore), 32'(e_sr));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h1234_5A5A));
      for (int i = 0; i < 3; i++) begin ma[i] = '0; ms[i] = 1'b0; end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "pc_load", 32'(pc_load), 0);
      chk("R1", "pc_load_vld", 32'(pc_load_vld), 0);
      chk("R1", "en_clr", 32'(en_clr), 0);
      chk("R1", "skip_restore", 32'(skip_restore), 0);
      for (int i = 0; i < 3; i++) step(0, 1, 11'h0, 0, 0, 0, "R1");

      // R2 / R3: overflow then pop past depth
      step(1, 0, 11'h101, 0, 0, 0, "R2");
      step(1, 0, 11'h202, 0, 0, 0, "R2");
      step(1, 0, 11'h303, 0, 0, 0, "R2");
      step(1, 0, 11'h404, 0, 0, 0, "R2");
      for (int i = 0; i < 4; i++) step(0, 1, 11'h0, 0, 0, 0, "R3");
      chk("R3", "bottom duplicated", 32'(pc_load), 32'h202);

      // R4: lookup push+pop copies middle into bottom
      step(1, 0, 11'h011, 0, 0, 0, "R4");
      step(1, 0, 11'h022, 0, 0, 0, "R4");
      step(1, 0, 11'h033, 0, 0, 0, "R4");
      step(1, 0, 11'h7AA, 0, 0, 0, "R4");
      step(0, 1, 11'h0, 0, 0, 0, "R4");
      chk("R4", "lookup result", 32'(pc_load), 32'h7AA);
      for (int i = 0; i < 3; i++) step(0, 1, 11'h0, 0, 0, 0, "R4");
      chk("R4", "bottom is old middle", 32'(pc_load), 32'h022);

      // R5: one-sample low is ignored
      step(0, 0, 11'h0, 0, 0, 1, "R5");
      set_pin(0);
      step(0, 0, 11'h0, 0, 0, 1, "R5");
      set_pin(1);
      for (int i = 0; i < 3; i++) step(0, 0, 11'h0, 0, 0, 1, "R5");
      // R5: qualifying pulse while disabled is ignored
      set_pin(0);
      for (int i = 0; i < 2; i++) step(0, 0, 11'h0, 0, 0, 0, "R5");
      set_pin(1);
      for (int i = 0; i < 3; i++) step(0, 0, 11'h0, 0, 0, 1, "R5");

      // R6 / R8: acknowledge with skip pending, then return
      set_pin(0);
      step(0, 0, 11'h120, 1, 0, 1, "R6");
      step(0, 0, 11'h121, 1, 0, 1, "R6");
      step(0, 0, 11'h123, 1, 0, 1, "R6");
      chk("R6", "vector", 32'(pc_load), 32'(VEC));
      chk("R6", "en_clr pulse", 32'(en_clr), 1);
      set_pin(1);
      step(0, 1, 11'h0, 0, 0, 0, "R8");
      chk("R8", "return address", 32'(pc_load), 32'h123);
      chk("R8", "skip restored", 32'(skip_restore), 1);

      // R7: deferral by chain, push and disable
      step(0, 0, 11'h0, 0, 0, 1, "R7");
      set_pin(0);
      step(0, 0, 11'h0, 0, 0, 1, "R7");
      step(0, 0, 11'h0, 0, 0, 1, "R7");
      step(0, 0, 11'h200, 0, 1, 1, "R7");
      step(1, 0, 11'h201, 0, 0, 1, "R7");
      step(0, 0, 11'h202, 0, 0, 0, "R7");
      step(0, 0, 11'h203, 0, 0, 1, "R7");
      chk("R7", "ack after chain", 32'(en_clr), 1);
      step(0, 1, 11'h0, 0, 0, 0, "R8");
      chk("R8", "no skip saved", 32'(skip_restore), 0);
      step(0, 1, 11'h0, 0, 0, 0, "R2");
      chk("R2", "plain push popped", 32'(pc_load), 32'h201);
      set_pin(1);

      // random mix
      for (int i = 0; i < 600; i++) begin
         int r;
         logic ps, po;
         r  = int'($urandom % 4);
         ps = (r == 0);
         po = (r == 1);
         step(ps, po, 11'($urandom), 1'($urandom), ($urandom % 4) == 0,
              ($urandom % 8) != 0, "R9");
         if (($urandom % 3) == 0) set_pin(!m_pin);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule